// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O bank controlled through a small memory-mapped register bus. Software drives pins by loading an output data register and an output enable register, and samples the pads through an input data register that always shows the synchronised pad level, whatever the pin's direction. Every configuration register can be loaded whole, or have selected bits set or cleared, through separate address aliases, so one pin can be changed without a read-modify-write.

Each pin watches its synchronised input for one of four trigger types, chosen by a type bit and a polarity bit. A detected trigger sets a sticky status bit. A pin contributes to the single bank interrupt only when its enable bit and its routing bit are both 1. Software acknowledges a pin by writing a 1 to its bit in the status clear alias, and takes pending pins in order from bit 0 upward.

Register slots are 16 bytes apart, and the alias is selected by address bits [3:2]: 0x0 loads the register, 0x4 sets bits, 0x8 clears bits, and 0xC is a no-op on write. A read from any alias of a slot returns the register's current value. Slot map: 0x00 input data (read-only), 0x10 output data, 0x20 output enable, 0x30 interrupt routing, 0x40 interrupt enable, 0x50 trigger type, 0x60 trigger polarity, 0x70 status. Reads of unmapped slots return 0.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, and pad_oe_o, pad_out_o and irq_o are 0.
- R2: A write to alias 0x0 loads the slot's register, to alias 0x4 ORs in the written ones, and to alias 0x8 clears the written ones. A read from any alias returns the current value, and unmapped slots (such as 0x90) read 0.
- R3: pad_out_o bit n equals output data bit n and pad_oe_o bit n equals output enable bit n. The input data register (0x00) returns the pad level through a two-flop synchroniser, so it is readable two clocks after the pad changes, whatever the direction.
- R4: Type bit 0 with polarity bit 1 makes a pin detect rising edges. The status bit is set once per edge and stays set until it is cleared.
- R5: Type bit 0 with polarity bit 0 makes a pin detect falling edges, with the same sticky status.
- R6: Type bit 1 with polarity bit 1 is active-high level detection. Status is set again on every cycle the pad stays high, so a clear has no lasting effect while the level holds.
- R7: Type bit 1 with polarity bit 0 is active-low level detection, the mirror case of R6.
- R8: Writing ones to the status clear alias (0x78) clears only those bits. Writes to status through 0x70 and 0x74 have no effect.
- R9: irq_o is the registered OR over all pins of status AND enable AND routing. It changes one clock after the status, enable or routing change, and stays 0 for a pending pin whose routing or enable bit is 0.
- R10: The input data register is read-only. Writes to 0x00 leave its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe; rdata_o is 0 when low |
| addr_i | input | 8 | Byte address (slot in [7:4], alias in [3:2]) |
| wdata_i | input | 32 | Write data, bit n for pin n |
| rdata_o | output | 32 | Combinational read data |
| pad_in_i | input | 32 | Asynchronous pad levels |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
On every cycle the assertions check that the interrupt output follows the gated status with one clock of delay, and that status bits never drop without a clear-alias write. They also check that an active-high level pin is always caught in status on the next clock, and that output data loads and output-enable clears reach the pads. Only the bench scenarios can show the trigger types over real pad sequences: the edge pins firing once and holding, the level pins firing again right after a clear, the falling-edge case, the read-only input register, and the way routing and enable each gate the interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int NUM_CFG   = 6;

  typedef enum logic [2:0] {
    SLOT_DIN   = 3'd0,
    SLOT_DOUT  = 3'd1,
    SLOT_OE    = 3'd2,
    SLOT_ROUTE = 3'd3,
    SLOT_IEN   = 3'd4,
    SLOT_TYPE  = 3'd5,
    SLOT_POL   = 3'd6,
    SLOT_STAT  = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    ACC_LOAD = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_NOP  = 2'd3
  } acc_e;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SLOT_LSB = 4,
  parameter int SLOT_W   = 4
) (
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [SLOT_W-1:0]    slot_o,
  output acc_e                 acc_o,
  output logic [NUM_SLOTS-1:0] wr_slot_o
);
  assign slot_o = addr_i[SLOT_LSB+SLOT_W-1:SLOT_LSB];
  assign acc_o  = acc_e'(addr_i[3:2]);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign wr_slot_o[s] = wr_i && (slot_o == SLOT_W'(s)) && (acc_o != ACC_NOP);
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  acc_e         acc_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (we_i) begin
      case (acc_i)
        ACC_LOAD: q_o <= wdata_i;
        ACC_SET:  q_o <= q_o | wdata_i;
        ACC_CLR:  q_o <= q_o & ~wdata_i;
        default:  q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_o <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= pad_i;
      sync_o <= meta_q;
      prev_o <= sync_o;
    end
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] type_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      case ({type_i[p], pol_i[p]})
        2'b00:   evt_o[p] = ~sync_i[p] &  prev_i[p];  // falling edge
        2'b01:   evt_o[p] =  sync_i[p] & ~prev_i[p];  // rising edge
        2'b10:   evt_o[p] = ~sync_i[p];               // low level
        default: evt_o[p] =  sync_i[p];               // high level
      endcase
    end
  end
endmodule

// File: rtl/gpio_stat_reg.sv
module gpio_stat_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] route_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_o <= (stat_o & ~clr_eff) | evt_i;
      irq_o  <= |(stat_o & ien_i & route_i);
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int SLOT_LSB = 4;
  localparam int SLOT_W   = ADDR_W - SLOT_LSB;

  logic [SLOT_W-1:0]    slot;
  acc_e                 acc;
  logic [NUM_SLOTS-1:0] wr_slot;

  logic [NUM_PINS-1:0] cfg_q [NUM_CFG];
  logic [NUM_PINS-1:0] dout_q, oe_q, route_q, ien_q, type_q, pol_q;
  logic [NUM_PINS-1:0] din_sync, din_prev, evt, stat_q;
  logic [NUM_PINS-1:0] rd_val;

  gpio_bus_decode #(
    .ADDR_W  (ADDR_W),
    .SLOT_LSB(SLOT_LSB),
    .SLOT_W  (SLOT_W)
  ) u_dec (
    .wr_i     (bus_wr_i),
    .addr_i   (addr_i),
    .slot_o   (slot),
    .acc_o    (acc),
    .wr_slot_o(wr_slot)
  );

  // config slots 1..NUM_CFG
  for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
    gpio_alias_reg #(.W(NUM_PINS)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_slot[c+1]),
      .acc_i  (acc),
      .wdata_i(wdata_i),
      .q_o    (cfg_q[c])
    );
  end

  assign dout_q  = cfg_q[int'(SLOT_DOUT)  - 1];
  assign oe_q    = cfg_q[int'(SLOT_OE)    - 1];
  assign route_q = cfg_q[int'(SLOT_ROUTE) - 1];
  assign ien_q   = cfg_q[int'(SLOT_IEN)   - 1];
  assign type_q  = cfg_q[int'(SLOT_TYPE)  - 1];
  assign pol_q   = cfg_q[int'(SLOT_POL)   - 1];

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pad_i (pad_in_i),
    .sync_o(din_sync),
    .prev_o(din_prev)
  );

  gpio_evt_detect #(.W(NUM_PINS)) u_det (
    .sync_i(din_sync),
    .prev_i(din_prev),
    .type_i(type_q),
    .pol_i (pol_q),
    .evt_o (evt)
  );

  gpio_stat_reg #(.W(NUM_PINS)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_we_i  (wr_slot[SLOT_STAT] && (acc == ACC_CLR)),
    .clr_mask_i(wdata_i),
    .evt_i     (evt),
    .ien_i     (ien_q),
    .route_i   (route_q),
    .stat_o    (stat_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (slot == SLOT_W'(SLOT_DIN)) begin
      rd_val = din_sync;
    end else if (slot == SLOT_W'(SLOT_STAT)) begin
      rd_val = stat_q;
    end else begin
      for (int c = 0; c < NUM_CFG; c++) begin
        if (slot == SLOT_W'(c + 1)) rd_val = cfg_q[c];
      end
    end
  end

  assign rdata_o   = bus_rd_i ? rd_val : '0;
  assign pad_out_o = dout_q;
  assign pad_oe_o  = oe_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_wr_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] stat_q,
  input logic [NUM_PINS-1:0] ien_q,
  input logic [NUM_PINS-1:0] route_q,
  input logic [NUM_PINS-1:0] type_q,
  input logic [NUM_PINS-1:0] pol_q,
  input logic [NUM_PINS-1:0] din_sync
);
  logic [ADDR_W-1:0] word;
  assign word = addr_i >> 2;

  // R9
  irq_follows_gated_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(stat_q & ien_q & route_q)));

  // R8
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && word == ADDR_W'(8'h1E)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R4
  edge_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && word == ADDR_W'(8'h1E)) |=>
      ((stat_q & $past(~type_q & stat_q)) == $past(~type_q & stat_q)));

  // R6
  level_high_caught_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(type_q & pol_q & din_sync)) == $past(type_q & pol_q & din_sync)));

  // R3
  dout_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && word == ADDR_W'(8'h04)) |=> pad_out_o == $past(wdata_i));

  // R2
  oe_clear_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && word == ADDR_W'(8'h0A)) |=> pad_oe_o == ($past(pad_oe_o) & ~$past(wdata_i)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bus_wr_i (bus_wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .irq_o    (irq_o),
  .stat_q   (stat_q),
  .ien_q    (ien_q),
  .route_q  (route_q),
  .type_q   (type_q),
  .pol_q    (pol_q),
  .din_sync (din_sync)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int OP_WR  = 0;
  localparam int OP_RD  = 1;
  localparam int OP_PAD = 2;
  localparam int OP_IRQ = 3;
  localparam int NV     = 39;

  // {op[1:0], req[3:0], addr[7:0], data[31:0], exp[31:0]}
  localparam logic [77:0] VECS [NV] = '{
    {2'd1, 4'd1, 8'h10, 32'h0,        32'h0},        // R1
    {2'd0, 4'd2, 8'h10, 32'hA5A50F0F, 32'h0},
    {2'd1, 4'd2, 8'h10, 32'h0,        32'hA5A50F0F}, // R2 load
    {2'd0, 4'd2, 8'h14, 32'h0000F000, 32'h0},
    {2'd1, 4'd2, 8'h10, 32'h0,        32'hA5A5FF0F}, // R2 set
    {2'd0, 4'd2, 8'h18, 32'hA5000000, 32'h0},
    {2'd1, 4'd2, 8'h10, 32'h0,        32'h00A5FF0F}, // R2 clear
    {2'd0, 4'd2, 8'h20, 32'hFFFF0000, 32'h0},
    {2'd1, 4'd2, 8'h24, 32'h0,        32'hFFFF0000}, // R2 read via alias
    {2'd1, 4'd2, 8'h90, 32'h0,        32'h0},        // R2 unmapped
    {2'd2, 4'd3, 8'h00, 32'h000000FF, 32'h0},
    {2'd1, 4'd3, 8'h00, 32'h0,        32'h000000FF}, // R3 input with oe set on other pins
    {2'd0, 4'd10, 8'h00, 32'hFFFFFFFF, 32'h0},
    {2'd1, 4'd10, 8'h00, 32'h0,       32'h000000FF}, // R10
    {2'd0, 4'd4, 8'h60, 32'h00000001, 32'h0},
    {2'd0, 4'd9, 8'h30, 32'h00000001, 32'h0},
    {2'd0, 4'd9, 8'h40, 32'h00000001, 32'h0},
    {2'd2, 4'd5, 8'h00, 32'h00000000, 32'h0},
    {2'd1, 4'd5, 8'h70, 32'h0,        32'h000000FE}, // R5 pins 1..7 fell
    {2'd3, 4'd9, 8'h00, 32'h0,        32'h0},        // R9 pin 0 clean
    {2'd2, 4'd4, 8'h00, 32'h00000001, 32'h0},
    {2'd1, 4'd4, 8'h70, 32'h0,        32'h000000FF}, // R4 rise
    {2'd3, 4'd9, 8'h00, 32'h0,        32'h1},        // R9
    {2'd0, 4'd8, 8'h78, 32'h00000002, 32'h0},
    {2'd1, 4'd8, 8'h70, 32'h0,        32'h000000FD}, // R8
    {2'd0, 4'd8, 8'h70, 32'h00000000, 32'h0},
    {2'd1, 4'd8, 8'h70, 32'h0,        32'h000000FD}, // R8 load ignored
    {2'd0, 4'd8, 8'h74, 32'hFFFFFFFF, 32'h0},
    {2'd1, 4'd8, 8'h70, 32'h0,        32'h000000FD}, // R8 set ignored
    {2'd0, 4'd8, 8'h78, 32'h00000001, 32'h0},
    {2'd3, 4'd9, 8'h00, 32'h0,        32'h0},        // R9 after ack
    {2'd1, 4'd8, 8'h70, 32'h0,        32'h000000FC}, // R8
    {2'd0, 4'd9, 8'h38, 32'h00000001, 32'h0},
    {2'd2, 4'd4, 8'h00, 32'h00000000, 32'h0},
    {2'd2, 4'd4, 8'h00, 32'h00000001, 32'h0},
    {2'd1, 4'd4, 8'h70, 32'h0,        32'h000000FD}, // R4 second rise
    {2'd3, 4'd9, 8'h00, 32'h0,        32'h0},        // R9 unrouted
    {2'd0, 4'd9, 8'h34, 32'h00000001, 32'h0},
    {2'd3, 4'd9, 8'h00, 32'h0,        32'h1}         // R9 routed again
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pad_in_i = '0;
  logic [31:0] pad_out_o;
  logic [31:0] pad_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  gpio_irq_bank u_gpio_irq_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_wr_i (bus_wr_i),
    .bus_rd_i (bus_rd_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pad_in_i (pad_in_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o),
    .irq_o    (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; bus_rd_i = 1'b1;
    #2;
    d = rdata_o;
    bus_rd_i = 1'b0;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk_i);
    pad_in_i = v;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state at the pads
    check("R1 pad_oe_o", pad_oe_o, 32'h0);
    check("R1 pad_out_o", pad_out_o, 32'h0);
    check("R1 irq_o", {31'h0, irq_o}, 32'h0);
    bus_read(8'h70, rd);
    check("R1 status", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [7:0]  a;
      logic [31:0] d, e;
      string       tag;
      {op, rq, a, d, e} = VECS[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      case (int'(op))
        OP_WR:  bus_write(a, d);
        OP_RD: begin
          @(negedge clk_i);
          bus_read(a, rd);
          check(tag, rd, e);
        end
        OP_PAD: set_pad(d);
        default: begin
          @(posedge clk_i);
          @(negedge clk_i);
          check(tag, {31'h0, irq_o}, e);
        end
      endcase
    end

    // R3 pads follow output data and enable
    check("R3 pad_out_o", pad_out_o, 32'h00A5FF0F);
    check("R3 pad_oe_o", pad_oe_o, 32'hFFFF0000);

    // R6 active-high level on pin 8
    bus_write(8'h64, 32'h100);
    bus_write(8'h54, 32'h100);
    bus_read(8'h70, rd);
    check("R6 idle", rd & 32'h100, 32'h0);
    set_pad(32'h101);
    bus_read(8'h70, rd);
    check("R6 level set", rd & 32'h100, 32'h100);
    bus_write(8'h78, 32'h100);
    bus_read(8'h70, rd);
    check("R6 refire after clear", rd & 32'h100, 32'h100);
    set_pad(32'h001);
    bus_write(8'h78, 32'h100);
    bus_read(8'h70, rd);
    check("R6 clear after release", rd & 32'h100, 32'h0);

    // R7 active-low level on pin 9 (pad already low)
    bus_write(8'h54, 32'h200);
    @(negedge clk_i);
    bus_read(8'h70, rd);
    check("R7 low level set", rd & 32'h200, 32'h200);
    set_pad(32'h201);
    bus_write(8'h78, 32'h200);
    bus_read(8'h70, rd);
    check("R7 clear after release", rd & 32'h200, 32'h0);
    bus_read(8'h00, rd);
    check("R3 input data", rd, 32'h201);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule